// File: doc/BRIEF.md
# I2C Register Access Target Port

This block lets a host microcontroller reach an on-chip register file over a two-wire I2C bus. The block is the bus target. It samples SCL and SDA with the system clock and detects START, repeated START and STOP conditions. It compares the bus device address with a fixed pattern that is completed by two strap pins. It then takes in a two-byte field that carries a 10-bit register address and a read flag.

The register address alone decides the word length. Addresses below a configurable boundary select parameter memory, where each word has 22 significant bits and travels as three bytes. Addresses at or above the boundary select 16-bit control registers, which travel as two bytes. Each word is zero-extended at its top to a whole number of bytes.

On a write, each completed word produces a one-cycle write strobe carrying the word and its address. On a read, the host first writes the register address. It then issues a repeated START with the read bit set, and the block fetches words from the register file and shifts them out MSB first.

Top module: `i2c_regport`

## Requirements
- R1: The 7-bit device address is {5'b01101, ad_pins[1:0]} and is followed by the R/W bit (0 = write). The block acknowledges only a matching address. After a mismatch it leaves SDA released and produces no write strobe until the next START.
- R2: The first byte after a write device address holds the register address bits 9:8 in bits 1:0 and the read flag in bit 2. Bits 7:3 of that byte are ignored. The second byte holds register address bits 7:0. The block pulls SDA low in the acknowledge slot of the device address byte, of both address bytes and of every data byte it receives.
- R3: A register address below PARAM_WORDS (default 512) selects a 3-byte word with 22 significant bits. Any other address selects a 2-byte word with 16 significant bits.
- R4: Bytes arrive most significant first. One clock cycle after the falling SCL edge that ends the acknowledge of a word's last byte, wr_en is high for exactly one cycle. At that point wr_addr holds the word's address and wr_data holds the word zero-extended. For a 3-byte word this means wr_data[23:22] = 0, whatever the top two bits of the first byte were. For a 2-byte word it means wr_data[23:16] = 0.
- R5: Further words in the same write transaction go to consecutive addresses. Each word takes the length that its own address selects.
- R6: A STOP or a START that arrives before a word is complete discards the bytes of that word received so far, and no strobe is issued for it.
- R7: When the read flag in the address field is 1, the block still acknowledges any data bytes that follow but issues no write strobe for them.
- R8: After a repeated START with the read bit set, the block pulses rd_en for one cycle with rd_addr set to the latched address. It samples rd_data one cycle after rd_en and shifts the word out MSB first, zero-extended as in R4.
- R9: If the master acknowledges the last byte of a word, the block fetches and sends the word at the next address. If the master does not acknowledge, the block releases SDA and stays silent until the next START.
- R10: sda_oe is high only in an acknowledge slot of the block or while it sends a 0 data bit. A STOP always releases it.
- R11: While rst_n is low, sda_oe, wr_en and rd_en are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| ad_pins | input | 2 | Strap pins forming the low two device address bits |
| wr_en | output | 1 | One-cycle write strobe to the register file |
| wr_addr | output | 10 | Register address of the strobed word |
| wr_data | output | 24 | Zero-extended word being written |
| rd_en | output | 1 | One-cycle read request to the register file |
| rd_addr | output | 10 | Register address of the requested word |
| rd_data | input | 24 | Word returned one cycle after rd_en |

## Verification
Two things can fall into the same cycle: a bus condition (START or STOP) being detected, and a word whose bytes are only partly assembled. Because that word is not complete, its write strobe must not fire. The bench provokes this by ending a transaction with STOP after one or two bytes of a three-byte parameter word, and by breaking a word with a repeated START. It judges the result by the number of write strobes seen at the port and by reading the address back to confirm that the old value is still there. Random multi-word writes and reads that cross the boundary between parameter and control addresses cover the case where the word length changes from one word to the next.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

    localparam int REG_ADDR_W = 10;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEV,
        PH_AHI,
        PH_ALO,
        PH_WR,
        PH_RD,
        PH_SKIP
    } phase_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_regport_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    typedef struct packed {
        logic [STAGES-1:0] scl_pipe;
        logic [STAGES-1:0] sda_pipe;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t d, q;
    logic  scl_s, sda_s;

    assign scl_s = q.scl_pipe[STAGES-1];
    assign sda_s = q.sda_pipe[STAGES-1];

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[STAGES-2:0], sda_i};
        d.scl_prev = scl_s;
        d.sda_prev = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    // Bus conditions are only recognised while SCL stayed high over both samples.
    always_comb begin
        ev.scl_rise = scl_s & ~q.scl_prev;
        ev.scl_fall = ~scl_s & q.scl_prev;
        ev.start    = scl_s & q.scl_prev & q.sda_prev & ~sda_s;
        ev.stop     = scl_s & q.scl_prev & ~q.sda_prev & sda_s;
        ev.sda      = sda_s;
    end

endmodule

// File: rtl/i2c_word_map.sv
module i2c_word_map
    import i2c_regport_pkg::*;
#(
    parameter int PARAM_WORDS = 512,
    parameter int PARAM_BITS  = 22,
    parameter int CTRL_BITS   = 16,
    parameter int W           = 24,
    parameter int IDX_W       = 2
) (
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [IDX_W-1:0]      bidx,
    input  logic [W-1:0]          rx_word,
    input  logic [W-1:0]          tx_word,
    output logic                  is_param,
    output logic [IDX_W-1:0]      last_idx,
    output logic [7:0]            tx_byte,
    output logic [W-1:0]          wr_word
);

    localparam int          PB    = (PARAM_BITS + 7) / 8;
    localparam int          CB    = (CTRL_BITS + 7) / 8;
    localparam logic [W-1:0] PMASK = {W{1'b1}} >> (W - PARAM_BITS);
    localparam logic [W-1:0] CMASK = {W{1'b1}} >> (W - CTRL_BITS);

    logic [W-1:0] mask;
    logic [W-1:0] tx_masked;
    logic [7:0]   shamt;

    always_comb begin
        is_param  = (32'(addr) < PARAM_WORDS);
        last_idx  = is_param ? IDX_W'(PB - 1) : IDX_W'(CB - 1);
        mask      = is_param ? PMASK : CMASK;
        wr_word   = rx_word & mask;
        tx_masked = tx_word & mask;
        shamt     = 8'(last_idx - bidx) * 8'd8;
        tx_byte   = 8'(tx_masked >> shamt);
    end

endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
    import i2c_regport_pkg::*;
#(
    parameter int W     = 24,
    parameter int IDX_W = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  bus_ev_t               ev,
    input  logic [6:0]            dev_addr,
    input  logic [IDX_W-1:0]      last_idx,
    input  logic [7:0]            tx_byte,
    input  logic [W-1:0]          wr_word,
    input  logic [W-1:0]          rd_data,
    output logic [REG_ADDR_W-1:0] cur_addr,
    output logic [IDX_W-1:0]      cur_bidx,
    output logic [W-1:0]          rx_word,
    output logic [W-1:0]          tx_word,
    output logic                  sda_oe,
    output logic                  wr_en,
    output logic [REG_ADDR_W-1:0] wr_addr,
    output logic [W-1:0]          wr_data,
    output logic                  rd_en,
    output logic [REG_ADDR_W-1:0] rd_addr
);

    typedef struct packed {
        phase_e                phase;
        logic                  ack_slot;
        logic                  own_ack;
        logic [3:0]            bitcnt;
        logic [7:0]            rx;
        logic [7:0]            tx;
        logic                  oe;
        logic                  rflag;
        logic [REG_ADDR_W-1:0] addr;
        logic [IDX_W-1:0]      bidx;
        logic [W-1:0]          word;
        logic                  wr_due;
        logic                  mack;
        logic                  wr_en;
        logic [REG_ADDR_W-1:0] wr_addr;
        logic [W-1:0]          wr_data;
        logic                  rd_en;
        logic                  rd_pend;
        logic [REG_ADDR_W-1:0] rd_addr;
        logic [W-1:0]          txword;
    } st_t;

    st_t d, q;

    always_comb begin
        d         = q;
        d.wr_en   = 1'b0;
        d.rd_en   = 1'b0;
        d.rd_pend = q.rd_en;
        if (q.rd_pend) begin
            d.txword = rd_data;
        end

        if (ev.stop) begin
            d.phase    = PH_IDLE;
            d.oe       = 1'b0;
            d.ack_slot = 1'b0;
            d.bidx     = '0;
            d.wr_due   = 1'b0;
        end else if (ev.start) begin
            d.phase    = PH_DEV;
            d.oe       = 1'b0;
            d.ack_slot = 1'b0;
            d.bitcnt   = '0;
            d.bidx     = '0;
            d.wr_due   = 1'b0;
        end else if (q.phase == PH_IDLE || q.phase == PH_SKIP) begin
            d.oe = 1'b0;
        end else if (q.ack_slot) begin
            // master acknowledge of a byte just sent: prefetch the next word here
            if (ev.scl_rise && q.phase == PH_RD && !q.own_ack) begin
                d.mack = ~ev.sda;
                if (!ev.sda) begin
                    if (q.bidx == last_idx) begin
                        d.bidx    = '0;
                        d.addr    = q.addr + 1'b1;
                        d.rd_en   = 1'b1;
                        d.rd_addr = q.addr + 1'b1;
                    end else begin
                        d.bidx = q.bidx + 1'b1;
                    end
                end
            end
            if (ev.scl_fall) begin
                d.ack_slot = 1'b0;
                d.bitcnt   = '0;
                d.oe       = 1'b0;
                if (q.wr_due) begin
                    d.wr_due  = 1'b0;
                    d.wr_en   = 1'b1;
                    d.wr_addr = q.addr;
                    d.wr_data = wr_word;
                    d.addr    = q.addr + 1'b1;
                    d.bidx    = '0;
                end
                if (q.phase == PH_RD) begin
                    if (q.mack) begin
                        d.tx = tx_byte;
                        d.oe = ~tx_byte[7];
                    end else begin
                        d.phase = PH_SKIP;
                    end
                end
            end
        end else if (q.phase == PH_RD) begin
            if (ev.scl_rise) begin
                d.bitcnt = q.bitcnt + 1'b1;
            end else if (ev.scl_fall) begin
                if (q.bitcnt == 4'd8) begin
                    d.ack_slot = 1'b1;
                    d.own_ack  = 1'b0;
                    d.oe       = 1'b0;
                    d.mack     = 1'b0;
                end else begin
                    d.tx = {q.tx[6:0], 1'b0};
                    d.oe = ~q.tx[6];
                end
            end
        end else begin
            if (ev.scl_rise) begin
                d.rx     = {q.rx[6:0], ev.sda};
                d.bitcnt = q.bitcnt + 1'b1;
            end else if (ev.scl_fall && q.bitcnt == 4'd8) begin
                d.ack_slot = 1'b1;
                d.own_ack  = 1'b1;
                d.oe       = 1'b1;
                case (q.phase)
                    PH_DEV: begin
                        if (q.rx[7:1] == dev_addr) begin
                            if (q.rx[0]) begin
                                d.phase   = PH_RD;
                                d.rd_en   = 1'b1;
                                d.rd_addr = q.addr;
                                d.bidx    = '0;
                                d.mack    = 1'b1;
                            end else begin
                                d.phase = PH_AHI;
                            end
                        end else begin
                            d.phase    = PH_SKIP;
                            d.oe       = 1'b0;
                            d.ack_slot = 1'b0;
                        end
                    end
                    PH_AHI: begin
                        d.rflag                       = q.rx[2];
                        d.addr[REG_ADDR_W-1:8]        = q.rx[REG_ADDR_W-9:0];
                        d.phase                       = PH_ALO;
                    end
                    PH_ALO: begin
                        d.addr[7:0] = q.rx;
                        d.phase     = PH_WR;
                        d.bidx      = '0;
                    end
                    PH_WR: begin
                        d.word = {q.word[W-9:0], q.rx};
                        if (!q.rflag) begin
                            if (q.bidx == last_idx) begin
                                d.wr_due = 1'b1;
                            end else begin
                                d.bidx = q.bidx + 1'b1;
                            end
                        end
                    end
                    default: d.oe = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cur_addr = q.addr;
    assign cur_bidx = q.bidx;
    assign rx_word  = q.word;
    assign tx_word  = q.txword;
    assign sda_oe   = q.oe;
    assign wr_en    = q.wr_en;
    assign wr_addr  = q.wr_addr;
    assign wr_data  = q.wr_data;
    assign rd_en    = q.rd_en;
    assign rd_addr  = q.rd_addr;

    a_r10_oe_legal: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> ((q.phase == PH_RD && !q.ack_slot) || (q.ack_slot && q.own_ack)));

    a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        ev.stop |=> !sda_oe);

    a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    a_r8_fetch_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);

    a_r1_skip_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_SKIP) |-> (!sda_oe && !rd_en));

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2c_regport_pkg::*;
#(
    parameter int         PARAM_WORDS = 512,
    parameter int         PARAM_BITS  = 22,
    parameter int         CTRL_BITS   = 16,
    parameter int         WORD_BYTES  = 3,
    parameter int         SYNC_STAGES = 2,
    parameter logic [4:0] DEV_UPPER   = 5'b01101
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    input  logic [1:0]            ad_pins,
    output logic                  wr_en,
    output logic [REG_ADDR_W-1:0] wr_addr,
    output logic [8*WORD_BYTES-1:0] wr_data,
    output logic                  rd_en,
    output logic [REG_ADDR_W-1:0] rd_addr,
    input  logic [8*WORD_BYTES-1:0] rd_data
);

    localparam int W     = 8 * WORD_BYTES;
    localparam int IDX_W = $clog2(WORD_BYTES);

    bus_ev_t               ev;
    logic [REG_ADDR_W-1:0] cur_addr;
    logic [IDX_W-1:0]      cur_bidx;
    logic [IDX_W-1:0]      last_idx;
    logic [W-1:0]          rx_word, tx_word, wr_word;
    logic [7:0]            tx_byte;
    logic                  is_param;

    i2c_line_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .scl_i(scl_i),
        .sda_i(sda_i),
        .ev   (ev)
    );

    i2c_word_map #(
        .PARAM_WORDS(PARAM_WORDS),
        .PARAM_BITS (PARAM_BITS),
        .CTRL_BITS  (CTRL_BITS),
        .W          (W),
        .IDX_W      (IDX_W)
    ) u_map (
        .addr    (cur_addr),
        .bidx    (cur_bidx),
        .rx_word (rx_word),
        .tx_word (tx_word),
        .is_param(is_param),
        .last_idx(last_idx),
        .tx_byte (tx_byte),
        .wr_word (wr_word)
    );

    i2c_link_fsm #(
        .W    (W),
        .IDX_W(IDX_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .dev_addr({DEV_UPPER, ad_pins}),
        .last_idx(last_idx),
        .tx_byte (tx_byte),
        .wr_word (wr_word),
        .rd_data (rd_data),
        .cur_addr(cur_addr),
        .cur_bidx(cur_bidx),
        .rx_word (rx_word),
        .tx_word (tx_word),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr)
    );

    a_r4_param_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(wr_addr) < PARAM_WORDS)) |-> ((wr_data >> PARAM_BITS) == '0));

    a_r4_ctrl_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (32'(wr_addr) >= PARAM_WORDS)) |-> ((wr_data >> CTRL_BITS) == '0));

    a_r11_quiet_reset: assert property (@(posedge clk)
        !rst_n |-> (!sda_oe && !wr_en && !rd_en));

endmodule

// File: tb/tb_i2c_regport.sv
module tb_i2c_regport;

    localparam int          PW   = 512;
    localparam int          H    = 10;
    localparam logic [4:0]  DEVU = 5'b01101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_bus;
    logic        sda_oe;
    logic [1:0]  ad_pins = 2'b10;
    logic        wr_en, rd_en;
    logic [9:0]  wr_addr, rd_addr;
    logic [23:0] wr_data;
    logic [23:0] rd_data = '0;

    always #5 clk = ~clk;
    assign sda_bus = m_sda & ~sda_oe;

    i2c_regport dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .ad_pins(ad_pins), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    logic [23:0] regs [0:1023];
    logic [23:0] expm [0:1023];
    logic [9:0]  log_a [0:255];
    logic [23:0] log_d [0:255];
    logic [23:0] wbuf [0:7];
    int          n_wr = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done = 0;

    always @(posedge clk) begin
        if (wr_en) begin
            regs[wr_addr]  <= wr_data;
            log_a[n_wr[7:0]] <= wr_addr;
            log_d[n_wr[7:0]] <= wr_data;
            n_wr <= n_wr + 1;
        end
        if (rd_en) rd_data <= regs[rd_addr];
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int nbytes(input logic [9:0] a);
        return (int'(a) < PW) ? 3 : 2;
    endfunction

    function automatic logic [23:0] fmask(input logic [9:0] a, input logic [23:0] v);
        return (int'(a) < PW) ? (v & 24'h3FFFFF) : (v & 24'h00FFFF);
    endfunction

    function automatic logic [7:0] byte_of(input logic [9:0] a, input logic [23:0] v, input int k);
        return 8'(v >> ((nbytes(a) - 1 - k) * 8));
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start;
        m_sda = 1'b1; m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0;
    endtask

    task automatic i2c_rstart;
        tick(2); m_sda = 1'b1; tick(H - 2);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0;
    endtask

    task automatic i2c_stop;
        tick(2); m_sda = 1'b0; tick(H - 2);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            tick(2); m_sda = b[i]; tick(H - 2);
            m_scl = 1'b1; tick(H);
            m_scl = 1'b0;
        end
        tick(2); m_sda = 1'b1; tick(H - 2);
        m_scl = 1'b1; tick(H / 2);
        ack = (sda_bus == 1'b0);
        tick(H / 2); m_scl = 1'b0;
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] b);
        b = '0;
        tick(2); m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick((i == 0) ? H - 2 : H);
            m_scl = 1'b1; tick(H / 2);
            b = {b[6:0], sda_bus};
            tick(H / 2); m_scl = 1'b0;
        end
        tick(2); m_sda = give_ack ? 1'b0 : 1'b1; tick(H - 2);
        m_scl = 1'b1; tick(H);
        m_scl = 1'b0; tick(2); m_sda = 1'b1;
    endtask

    // R2/R4/R5/R7: write n words from wbuf starting at a; junk fills ignored bits 7:3
    task automatic do_write(input logic [9:0] a, input int n, input bit rf);
        bit ak;
        int s0;
        logic [4:0] junk;
        s0 = n_wr;
        junk = 5'($urandom);
        i2c_start;
        wbyte({DEVU, ad_pins, 1'b0}, ak);
        chk(ak, "R1 device ack", 32'(ak), 1);
        wbyte({junk, rf, a[9:8]}, ak);
        chk(ak, "R2 address high ack", 32'(ak), 1);
        wbyte(a[7:0], ak);
        chk(ak, "R2 address low ack", 32'(ak), 1);
        for (int w = 0; w < n; w++) begin
            for (int k = 0; k < nbytes(a + 10'(w)); k++) begin
                wbyte(byte_of(a + 10'(w), wbuf[w], k), ak);
                chk(ak, "R2 data ack", 32'(ak), 1);
            end
        end
        i2c_stop;
        tick(4);
        chk(sda_oe == 1'b0, "R10 released after stop", 32'(sda_oe), 0);
        if (rf) begin
            chk(n_wr == s0, "R7 no strobe with read flag", n_wr - s0, 0);
        end else begin
            chk(n_wr - s0 == n, "R5 strobe count", n_wr - s0, n);
            for (int w = 0; w < n; w++) begin
                logic [9:0] ea;
                ea = a + 10'(w);
                chk(log_a[8'(s0 + w)] == ea, "R5 strobe address", 32'(log_a[8'(s0 + w)]), 32'(ea));
                chk(log_d[8'(s0 + w)] == fmask(ea, wbuf[w]), "R4 strobe data",
                    32'(log_d[8'(s0 + w)]), 32'(fmask(ea, wbuf[w])));
                expm[ea] = fmask(ea, wbuf[w]);
            end
        end
    endtask

    // R8/R9: set address with the read flag, repeated START, read n words
    task automatic do_read(input logic [9:0] a, input int n);
        bit ak;
        logic [7:0] b;
        i2c_start;
        wbyte({DEVU, ad_pins, 1'b0}, ak);
        wbyte({5'b0, 1'b1, a[9:8]}, ak);
        wbyte(a[7:0], ak);
        i2c_rstart;
        wbyte({DEVU, ad_pins, 1'b1}, ak);
        chk(ak, "R8 read address ack", 32'(ak), 1);
        for (int w = 0; w < n; w++) begin
            logic [9:0] ea;
            ea = a + 10'(w);
            for (int k = 0; k < nbytes(ea); k++) begin
                bit last;
                last = (w == n - 1) && (k == nbytes(ea) - 1);
                rbyte(!last, b);
                chk(b == byte_of(ea, fmask(ea, expm[ea]), k), (w == 0) ? "R8 read byte" : "R9 continued byte",
                    32'(b), 32'(byte_of(ea, fmask(ea, expm[ea]), k)));
            end
        end
        tick(6);
        chk(sda_oe == 1'b0, "R9 released after nack", 32'(sda_oe), 0);
        i2c_stop;
        tick(4);
    endtask

    task automatic report;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        report;
    end

    initial begin
        bit ak;
        int s0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 1024; i++) begin
            regs[i] = '0;
            expm[i] = '0;
        end
        tick(3);
        chk(sda_oe == 0, "R11 sda_oe in reset", 32'(sda_oe), 0);
        chk(wr_en == 0, "R11 wr_en in reset", 32'(wr_en), 0);
        chk(rd_en == 0, "R11 rd_en in reset", 32'(rd_en), 0);
        rst_n = 1'b1;
        tick(5);

        // R1: wrong strap bits -> no ack, later bytes ignored
        s0 = n_wr;
        i2c_start;
        wbyte({DEVU, ~ad_pins, 1'b0}, ak);
        chk(!ak, "R1 mismatch nack", 32'(ak), 0);
        wbyte(8'h00, ak);
        chk(!ak, "R1 ignored byte", 32'(ak), 0);
        wbyte(8'h05, ak);
        wbyte(8'hFF, ak); wbyte(8'hFF, ak); wbyte(8'hFF, ak);
        i2c_stop;
        tick(4);
        chk(n_wr == s0, "R1 no strobe after mismatch", n_wr - s0, 0);

        // R3/R4: parameter word with top bits set in first byte
        wbuf[0] = 24'hFFFFFF;
        do_write(10'd5, 1, 1'b0);
        do_read(10'd5, 1);

        // R3: control word
        wbuf[0] = 24'h12A5C3;
        do_write(10'd700, 1, 1'b0);
        do_read(10'd700, 1);

        // R5/R3: across the parameter/control boundary
        wbuf[0] = 24'h2ABCDE;
        wbuf[1] = 24'h00BEEF;
        wbuf[2] = 24'h001234;
        do_write(10'(PW - 1), 3, 1'b0);
        do_read(10'(PW - 1), 3);

        // R6: partial word then STOP
        s0 = n_wr;
        i2c_start;
        wbyte({DEVU, ad_pins, 1'b0}, ak);
        wbyte(8'h00, ak);
        wbyte(8'd9, ak);
        wbyte(8'h11, ak);
        wbyte(8'h22, ak);
        i2c_stop;
        tick(4);
        chk(n_wr == s0, "R6 partial word and stop", n_wr - s0, 0);
        // R6: partial word then repeated START
        i2c_start;
        wbyte({DEVU, ad_pins, 1'b0}, ak);
        wbyte(8'h00, ak);
        wbyte(8'd9, ak);
        wbyte(8'h33, ak);
        i2c_rstart;
        wbyte({DEVU, ad_pins, 1'b0}, ak);
        i2c_stop;
        tick(4);
        chk(n_wr == s0, "R6 partial word and restart", n_wr - s0, 0);
        do_read(10'd9, 1);

        // R7: read flag set on a write
        wbuf[0] = 24'h155555;
        do_write(10'd20, 1, 1'b1);
        do_read(10'd20, 1);

        // constrained random traffic over both ranges
        for (int it = 0; it < 10; it++) begin
            logic [9:0] a;
            int n;
            a = 10'($urandom_range(0, 1000));
            n = int'($urandom_range(1, 3));
            for (int w = 0; w < n; w++) wbuf[w] = 24'($urandom);
            do_write(a, n, 1'b0);
            do_read(a, n);
        end

        report;
    end

endmodule